// File: doc/BRIEF.md
# DMA Window Address Translator

This block turns addresses arriving from an I/O bus into host physical addresses. Four programmable windows each own a base, a mask and a translated-base register. A window matches when the bus address and the window base agree on the compare field, bits 31:20, apart from the bits that the window mask opens. A matching window rewrites the address in one of two ways. Direct mode splices the low bits of the bus address onto the translated base. Scatter-gather mode reads a 64-bit page entry from memory and builds the address from that entry.

Software programs the windows and a control register through a 64-bit register port. The registers sit 64 bytes apart. Translation requests use a valid/ready handshake, and only one request is in flight at a time. The page-entry read goes out on its own request/response port. A bus address that no enabled window claims comes back unchanged.

Top module: `dma_win_xlate`

## Requirements
- R1: After reset every window base, mask and translated-base register reads 0, and the control register reads 0x0000_0021_0010_0000 (bit 20 set, bit 32 set, value 2 in the field starting at bit 36).
- R2: The register index is the byte offset shifted right by 6. Window i has its base at index i, its mask at index 4+i and its translated base at index 8+i, and the control register is at index 12. All of these read back the last value written, and csr_ack rises in the cycle after csr_valid.
- R3: Index 13 (error status) and index 14 (invalidate-all) always read 0, and writes to them change no register.
- R4: Any other index returns csr_err=1 with csr_rdata=0, and a write there changes no register.
- R5: Window i matches when (bus & M) == (base_i & M), with M = ~mask_i & 0xFFF0_0000. Bus bits outside 31:20 take no part in the compare.
- R6: Base bit 0 enables a window. A window that matches but is not enabled is skipped.
- R7: Windows are checked in order from 0 to 3 and the lowest enabled match wins. With no hit, the full 64-bit bus address is returned unchanged.
- R8: Base bit 1 clear selects direct mode: K = (mask_i & 0xFFF0_0000) | 0xF_FFFF, and the result is (tba_i & ~K) | (bus & K).
- R9: Base bit 1 set selects scatter-gather mode. With W = mask_i & 0xFFF0_0000, one page-entry read is issued at (tba_i & ~((W>>10)|0x3FF)) | ((bus & (W | 0xFE000)) >> 10). The address and the valid signal are held until pte_req_ready.
- R10: In scatter-gather mode the result is ((pte & ~1) << 12) | (bus & 0x1FFF).
- R11: Every translated result, in either mode, is cut to its low 34 bits.
- R12: xl_req_ready is low while a translation is in flight. xl_rsp_valid and xl_rsp_addr are held until xl_rsp_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csr_valid | input | 1 | Register access strobe |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Byte offset of the register |
| csr_wdata | input | 64 | Write data |
| csr_ack | output | 1 | Access completed (one cycle after csr_valid) |
| csr_rdata | output | 64 | Read data |
| csr_err | output | 1 | Index not implemented |
| xl_req_valid | input | 1 | Translation request valid |
| xl_req_ready | output | 1 | Translator idle, accepts a request |
| xl_req_addr | input | 64 | Bus address to translate |
| xl_rsp_valid | output | 1 | Translated address valid |
| xl_rsp_ready | input | 1 | Consumer takes the response |
| xl_rsp_addr | output | 64 | Translated (or passed-through) address |
| pte_req_valid | output | 1 | Page-entry read request |
| pte_req_ready | input | 1 | Memory accepts the read |
| pte_req_addr | output | 64 | Page-entry address |
| pte_rsp_valid | input | 1 | Page-entry data valid |
| pte_rsp_data | input | 64 | Page-entry data |

## Verification
The bench builds the block with its defaults: four windows, a 34-bit physical result and a 6-bit register index. With four windows, two windows can claim the same address, so the bench can check that the lowest enabled window wins and that a lower disabled window is skipped. It also checks a scatter-gather window next to a direct one. The 6-bit index leaves room for unimplemented indices above the error and invalidate registers. The 34-bit cut is reached with translated bases and page entries that have bits set above bit 33.

// File: rtl/dwx_pkg.sv
package dwx_pkg;

  localparam logic [63:0] CMP_FIELD   = 64'h0000_0000_FFF0_0000;
  localparam logic [63:0] CTRL_RESET  = 64'h0000_0021_0010_0000;
  localparam logic [63:0] DIRECT_LOW  = 64'h0000_0000_000F_FFFF;
  localparam logic [63:0] SG_PAGE_SEL = 64'h0000_0000_000F_E000;
  localparam logic [63:0] SG_OFFSET   = 64'h0000_0000_0000_1FFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_EVAL, ST_PTE_REQ, ST_PTE_WAIT, ST_RESP
  } xl_state_e;

  function automatic logic [63:0] clip_pa(input logic [63:0] x, input int pa_w);
    logic [63:0] keep;
    keep = (64'h1 << pa_w) - 64'h1;
    return x & keep;
  endfunction

  function automatic logic [63:0] cmp_mask(input logic [63:0] m);
    return ~m & CMP_FIELD;
  endfunction

  function automatic logic [63:0] direct_xlate(input logic [63:0] tba,
                                               input logic [63:0] m,
                                               input logic [63:0] bus,
                                               input int pa_w);
    logic [63:0] k;
    k = (m & CMP_FIELD) | DIRECT_LOW;
    return clip_pa((tba & ~k) | (bus & k), pa_w);
  endfunction

  function automatic logic [63:0] pte_addr(input logic [63:0] tba,
                                           input logic [63:0] m,
                                           input logic [63:0] bus);
    logic [63:0] w;
    w = m & CMP_FIELD;
    return (tba & ~((w >> 10) | 64'h3FF)) | ((bus & (w | SG_PAGE_SEL)) >> 10);
  endfunction

  function automatic logic [63:0] sg_xlate(input logic [63:0] pte,
                                           input logic [63:0] bus,
                                           input int pa_w);
    return clip_pa(((pte & ~64'h1) << 12) | (bus & SG_OFFSET), pa_w);
  endfunction

endpackage

// File: rtl/dwx_csr.sv
module dwx_csr import dwx_pkg::*; #(
  parameter int NUM_WIN = 4,
  parameter int IDX_W   = 6,
  localparam int OFF_W  = IDX_W + 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        csr_valid,
  input  logic                        csr_we,
  input  logic [OFF_W-1:0]            csr_addr,
  input  logic [63:0]                 csr_wdata,
  output logic                        csr_ack,
  output logic [63:0]                 csr_rdata,
  output logic                        csr_err,
  output logic [NUM_WIN-1:0][63:0]    win_base,
  output logic [NUM_WIN-1:0][63:0]    win_mask,
  output logic [NUM_WIN-1:0][63:0]    win_tba
);

  localparam int IX_MASK = NUM_WIN;
  localparam int IX_TBA  = 2 * NUM_WIN;
  localparam int IX_CTRL = 3 * NUM_WIN;
  localparam int IX_ERR  = IX_CTRL + 1;
  localparam int IX_INV  = IX_CTRL + 2;

  logic [NUM_WIN-1:0][63:0] base_q, mask_q, tba_q;
  logic [63:0]              ctrl_q;
  logic [IDX_W-1:0]         idx;
  int                       idx_i;
  logic                     known;
  logic                     zero_reg;
  logic                     zero_q;
  logic [63:0]              rd_val;

  assign idx   = csr_addr[OFF_W-1:6];
  assign idx_i = int'(idx);

  always_comb begin
    known    = 1'b0;
    zero_reg = 1'b0;
    rd_val   = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (idx_i == i)           begin known = 1'b1; rd_val = base_q[i]; end
      if (idx_i == IX_MASK + i) begin known = 1'b1; rd_val = mask_q[i]; end
      if (idx_i == IX_TBA + i)  begin known = 1'b1; rd_val = tba_q[i];  end
    end
    if (idx_i == IX_CTRL) begin known = 1'b1; rd_val = ctrl_q; end
    if (idx_i == IX_ERR || idx_i == IX_INV) begin
      known    = 1'b1;
      zero_reg = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q    <= '0;
      mask_q    <= '0;
      tba_q     <= '0;
      ctrl_q    <= CTRL_RESET;
      csr_ack   <= 1'b0;
      csr_rdata <= '0;
      csr_err   <= 1'b0;
      zero_q    <= 1'b0;
    end else begin
      csr_ack <= csr_valid;
      if (csr_valid) begin
        csr_err   <= !known;
        csr_rdata <= rd_val;
        zero_q    <= zero_reg;
        if (csr_we) begin
          for (int i = 0; i < NUM_WIN; i++) begin
            if (idx_i == i)           base_q[i] <= csr_wdata;
            if (idx_i == IX_MASK + i) mask_q[i] <= csr_wdata;
            if (idx_i == IX_TBA + i)  tba_q[i]  <= csr_wdata;
          end
          if (idx_i == IX_CTRL) ctrl_q <= csr_wdata;
        end
      end
    end
  end

  assign win_base = base_q;
  assign win_mask = mask_q;
  assign win_tba  = tba_q;

  // R2: every access is acknowledged in the following cycle
  a_r2_ack_next: assert property (@(posedge clk) disable iff (rst)
    csr_valid |=> csr_ack);
  // R4: an unimplemented index carries no data
  a_r4_err_no_data: assert property (@(posedge clk) disable iff (rst)
    csr_ack && csr_err |-> csr_rdata == 64'h0);
  // R3: status and invalidate registers read as zero
  a_r3_zero_read: assert property (@(posedge clk) disable iff (rst)
    csr_ack && zero_q |-> csr_rdata == 64'h0 && !csr_err);

endmodule

// File: rtl/dwx_win_match.sv
module dwx_win_match import dwx_pkg::*; #(
  parameter int NUM_WIN = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [63:0]              bus_addr,
  input  logic [NUM_WIN-1:0][63:0] win_base,
  input  logic [NUM_WIN-1:0][63:0] win_mask,
  input  logic [NUM_WIN-1:0][63:0] win_tba,
  output logic                     hit,
  output logic                     hit_sg,
  output logic [63:0]              hit_mask,
  output logic [63:0]              hit_tba
);

  logic [NUM_WIN-1:0] cand;
  logic [NUM_WIN-1:0] grant;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic [63:0] m;
    assign m       = cmp_mask(win_mask[g]);
    assign cand[g] = win_base[g][0] && ((bus_addr & m) == (win_base[g] & m));
  end

  always_comb begin
    grant    = '0;
    hit_sg   = 1'b0;
    hit_mask = '0;
    hit_tba  = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        hit_sg   = win_base[i][1];
        hit_mask = win_mask[i];
        hit_tba  = win_tba[i];
      end
    end
  end

  assign hit = |grant;

  // R7: at most one window claims an address
  a_r7_one_winner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  // R6: the grant never lands on a disabled window
  a_r6_enabled_only: assert property (@(posedge clk) disable iff (rst)
    (grant & ~cand) == '0);

endmodule

// File: rtl/dwx_xlate_fsm.sv
module dwx_xlate_fsm import dwx_pkg::*; #(
  parameter int PA_W = 34
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        xl_req_valid,
  output logic        xl_req_ready,
  input  logic [63:0] xl_req_addr,
  output logic        xl_rsp_valid,
  input  logic        xl_rsp_ready,
  output logic [63:0] xl_rsp_addr,
  output logic        pte_req_valid,
  input  logic        pte_req_ready,
  output logic [63:0] pte_req_addr,
  input  logic        pte_rsp_valid,
  input  logic [63:0] pte_rsp_data,
  output logic [63:0] bus_q,
  input  logic        hit,
  input  logic        hit_sg,
  input  logic [63:0] hit_mask,
  input  logic [63:0] hit_tba
);

  xl_state_e   state_q;
  logic [63:0] result_q;
  logic [63:0] paddr_q;
  logic        hit_q;
  logic        accept;
  logic        pte_fire;

  assign accept   = xl_req_valid && state_q == ST_IDLE;
  assign pte_fire = pte_req_valid && pte_req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      bus_q    <= '0;
      result_q <= '0;
      paddr_q  <= '0;
      hit_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          bus_q   <= xl_req_addr;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          hit_q <= hit;
          if (!hit) begin
            result_q <= bus_q;
            state_q  <= ST_RESP;
          end else if (!hit_sg) begin
            result_q <= direct_xlate(hit_tba, hit_mask, bus_q, PA_W);
            state_q  <= ST_RESP;
          end else begin
            paddr_q <= pte_addr(hit_tba, hit_mask, bus_q);
            state_q <= ST_PTE_REQ;
          end
        end
        ST_PTE_REQ: if (pte_fire) state_q <= ST_PTE_WAIT;
        ST_PTE_WAIT: if (pte_rsp_valid) begin
          result_q <= sg_xlate(pte_rsp_data, bus_q, PA_W);
          state_q  <= ST_RESP;
        end
        ST_RESP: if (xl_rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign xl_req_ready  = state_q == ST_IDLE;
  assign xl_rsp_valid  = state_q == ST_RESP;
  assign xl_rsp_addr   = result_q;
  assign pte_req_valid = state_q == ST_PTE_REQ;
  assign pte_req_addr  = paddr_q;

  // R12: response held until taken
  a_r12_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    xl_rsp_valid && !xl_rsp_ready |=> xl_rsp_valid && $stable(xl_rsp_addr));
  // R12: no new request while one is in flight
  a_r12_single: assert property (@(posedge clk) disable iff (rst)
    !(xl_req_ready && (xl_rsp_valid || pte_req_valid)));
  // R9: page-entry read held until accepted
  a_r9_pte_hold: assert property (@(posedge clk) disable iff (rst)
    pte_req_valid && !pte_req_ready |=> pte_req_valid && $stable(pte_req_addr));
  // R11: translated results stay within the physical width
  a_r11_clip: assert property (@(posedge clk) disable iff (rst)
    xl_rsp_valid && hit_q |-> (xl_rsp_addr >> PA_W) == 64'h0);
  // R7: a miss passes the bus address through
  a_r7_passthru: assert property (@(posedge clk) disable iff (rst)
    xl_rsp_valid && !hit_q |-> xl_rsp_addr == bus_q);

endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate import dwx_pkg::*; #(
  parameter int NUM_WIN = 4,
  parameter int PA_W    = 34,
  parameter int IDX_W   = 6,
  localparam int OFF_W  = IDX_W + 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csr_valid,
  input  logic             csr_we,
  input  logic [OFF_W-1:0] csr_addr,
  input  logic [63:0]      csr_wdata,
  output logic             csr_ack,
  output logic [63:0]      csr_rdata,
  output logic             csr_err,
  input  logic             xl_req_valid,
  output logic             xl_req_ready,
  input  logic [63:0]      xl_req_addr,
  output logic             xl_rsp_valid,
  input  logic             xl_rsp_ready,
  output logic [63:0]      xl_rsp_addr,
  output logic             pte_req_valid,
  input  logic             pte_req_ready,
  output logic [63:0]      pte_req_addr,
  input  logic             pte_rsp_valid,
  input  logic [63:0]      pte_rsp_data
);

  logic [NUM_WIN-1:0][63:0] win_base, win_mask, win_tba;
  logic [63:0] bus_q;
  logic        hit, hit_sg;
  logic [63:0] hit_mask, hit_tba;

  dwx_csr #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_csr (
    .clk(clk), .rst(rst),
    .csr_valid(csr_valid), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_ack(csr_ack), .csr_rdata(csr_rdata),
    .csr_err(csr_err),
    .win_base(win_base), .win_mask(win_mask), .win_tba(win_tba)
  );

  dwx_win_match #(.NUM_WIN(NUM_WIN)) u_match (
    .clk(clk), .rst(rst), .bus_addr(bus_q),
    .win_base(win_base), .win_mask(win_mask), .win_tba(win_tba),
    .hit(hit), .hit_sg(hit_sg), .hit_mask(hit_mask), .hit_tba(hit_tba)
  );

  dwx_xlate_fsm #(.PA_W(PA_W)) u_fsm (
    .clk(clk), .rst(rst),
    .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready),
    .xl_req_addr(xl_req_addr),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready),
    .xl_rsp_addr(xl_rsp_addr),
    .pte_req_valid(pte_req_valid), .pte_req_ready(pte_req_ready),
    .pte_req_addr(pte_req_addr),
    .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data),
    .bus_q(bus_q), .hit(hit), .hit_sg(hit_sg),
    .hit_mask(hit_mask), .hit_tba(hit_tba)
  );

endmodule

// File: tb/dma_win_xlate_bench.sv
module dma_win_xlate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_valid = 0, csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic        csr_ack, csr_err;
  logic [63:0] csr_rdata;
  logic        xl_req_valid = 0, xl_rsp_ready = 0;
  logic [63:0] xl_req_addr = '0;
  logic        xl_req_ready, xl_rsp_valid;
  logic [63:0] xl_rsp_addr;
  logic        pte_req_valid, pte_req_ready = 0, pte_rsp_valid = 0;
  logic [63:0] pte_req_addr, pte_rsp_data = '0;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  dma_win_xlate u_dma_win_xlate (
    .clk(clk), .rst(rst),
    .csr_valid(csr_valid), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_ack(csr_ack), .csr_rdata(csr_rdata),
    .csr_err(csr_err),
    .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready),
    .xl_req_addr(xl_req_addr),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready),
    .xl_rsp_addr(xl_rsp_addr),
    .pte_req_valid(pte_req_valid), .pte_req_ready(pte_req_ready),
    .pte_req_addr(pte_req_addr),
    .pte_rsp_valid(pte_rsp_valid), .pte_rsp_data(pte_rsp_data)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic csr(input bit we, input int idx, input logic [63:0] wd,
                     output logic [63:0] rd, output logic err);
    @(negedge clk);
    csr_valid = 1; csr_we = we; csr_addr = 12'(idx << 6); csr_wdata = wd;
    @(negedge clk);
    csr_valid = 0; csr_we = 0;
    chk("R2 ack", {63'h0, csr_ack}, 64'h1);
    rd = csr_rdata; err = csr_err;
  endtask

  task automatic wr(input int idx, input logic [63:0] v);
    logic [63:0] rd; logic e;
    csr(1, idx, v, rd, e);
  endtask

  task automatic rd_chk(input string req, input int idx, input logic [63:0] exp);
    logic [63:0] rd; logic e;
    csr(0, idx, 64'h0, rd, e);
    chk(req, rd, exp);
    chk({req, " err"}, {63'h0, e}, 64'h0);
  endtask

  // one translation; when sg is set, serves one page-entry read
  task automatic xlate(input logic [63:0] bus, input bit sg, input logic [63:0] pte,
                       input int hold, output logic [63:0] res, output logic [63:0] pa);
    logic [63:0] first;
    pa = '0;
    @(negedge clk);
    xl_req_valid = 1; xl_req_addr = bus;
    while (!xl_req_ready) @(negedge clk);
    @(negedge clk);
    xl_req_valid = 0;
    if (sg) begin
      while (!pte_req_valid) @(negedge clk);
      pa = pte_req_addr;
      repeat (2) begin
        @(negedge clk);
        chk("R9 pte hold valid", {63'h0, pte_req_valid}, 64'h1);
        chk("R9 pte hold addr", pte_req_addr, pa);
        chk("R12 busy", {63'h0, xl_req_ready}, 64'h0);
      end
      pte_req_ready = 1;
      @(negedge clk);
      pte_req_ready = 0;
      pte_rsp_valid = 1; pte_rsp_data = pte;
      @(negedge clk);
      pte_rsp_valid = 0;
    end
    while (!xl_rsp_valid) @(negedge clk);
    first = xl_rsp_addr;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R12 rsp hold valid", {63'h0, xl_rsp_valid}, 64'h1);
      chk("R12 rsp hold addr", xl_rsp_addr, first);
    end
    xl_rsp_ready = 1;
    @(negedge clk);
    xl_rsp_ready = 0;
    chk("R12 rsp dropped", {63'h0, xl_rsp_valid}, 64'h0);
    res = first;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 12; i++) rd_chk("R1 window reg reset", i, 64'h0);
    rd_chk("R1 control reset", 12, 64'h0000_0021_0010_0000);
  endtask

  task automatic t_csr_rw;
    for (int i = 0; i < 12; i++) wr(i, 64'hA5A5_0000_0000_0000 | 64'(i * 3 + 1));
    wr(12, 64'h1234_5678_9ABC_DEF0);
    for (int i = 0; i < 12; i++) rd_chk("R2 readback", i, 64'hA5A5_0000_0000_0000 | 64'(i * 3 + 1));
    rd_chk("R2 control readback", 12, 64'h1234_5678_9ABC_DEF0);
    for (int i = 0; i < 12; i++) wr(i, 64'h0);
  endtask

  task automatic t_zero_regs;
    wr(13, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(14, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_chk("R3 error reg", 13, 64'h0);
    rd_chk("R3 invalidate reg", 14, 64'h0);
    rd_chk("R3 control untouched", 12, 64'h1234_5678_9ABC_DEF0);
    rd_chk("R3 base0 untouched", 0, 64'h0);
  endtask

  task automatic t_unknown;
    logic [63:0] rd; logic e;
    csr(1, 20, 64'hFFFF_FFFF_FFFF_FFFF, rd, e);
    chk("R4 write err", {63'h0, e}, 64'h1);
    csr(0, 63, 64'h0, rd, e);
    chk("R4 read err", {63'h0, e}, 64'h1);
    chk("R4 read data", rd, 64'h0);
    rd_chk("R4 control untouched", 12, 64'h1234_5678_9ABC_DEF0);
    rd_chk("R4 tba3 untouched", 11, 64'h0);
  endtask

  task automatic t_direct;
    logic [63:0] r, pa;
    xlate(64'hDEAD_BEEF_5000_0123, 0, 0, 0, r, pa);
    chk("R7 miss passthrough", r, 64'hDEAD_BEEF_5000_0123);
    // window 1: 256 MB direct window at 0x4000_0000 -> 0x2_0000_0000
    wr(1, 64'h4000_0001); wr(5, 64'h0FF0_0000); wr(9, 64'h2_0000_0000);
    xlate(64'h4567_89AB, 0, 0, 3, r, pa);
    chk("R8 direct", r, 64'h2_0567_89AB);
    // window 0 matches too but is disabled
    wr(0, 64'h4000_0000); wr(4, 64'h0FF0_0000); wr(8, 64'h1_0000_0000);
    xlate(64'h4567_89AB, 0, 0, 0, r, pa);
    chk("R6 disabled skipped", r, 64'h2_0567_89AB);
    wr(0, 64'h4000_0001);
    xlate(64'h4567_89AB, 0, 0, 0, r, pa);
    chk("R7 lowest wins", r, 64'h1_0567_89AB);
    wr(0, 64'h4000_0000);
    xlate(64'h1_4567_89AB, 0, 0, 0, r, pa);
    chk("R5 upper bits ignored", r, 64'h2_0567_89AB);
    xlate(64'h5567_89AB, 0, 0, 0, r, pa);
    chk("R5 compare field mismatch", r, 64'h5567_89AB);
    wr(9, 64'hF_3000_0000);
    xlate(64'h4567_89AB, 0, 0, 0, r, pa);
    chk("R11 direct clip", r, 64'h3_3567_89AB);
  endtask

  task automatic t_sg;
    logic [63:0] r, pa;
    // window 2: 1 MB scatter-gather at 0x8000_0000, table at 0x1_0000_0000
    wr(2, 64'h8000_0003); wr(6, 64'h0); wr(10, 64'h1_0000_0000);
    xlate(64'h8001_2345, 1, 64'h0012_3457, 2, r, pa);
    chk("R9 pte addr", pa, 64'h1_0000_0048);
    chk("R10 sg result", r, 64'h1_2345_6345);
    xlate(64'h8001_2345, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, r, pa);
    chk("R11 sg clip", r, 64'h3_FFFF_E345);
    wr(6, 64'h0030_0000);
    xlate(64'h8031_2345, 1, 64'h0000_0000_0000_0010, 0, r, pa);
    chk("R9 pte addr wide window", pa, 64'h1_0000_0C48);
    chk("R10 sg result wide window", r, 64'h0001_0345);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R12 idle after reset", {63'h0, xl_req_ready}, 64'h1);
    t_reset();
    t_csr_rw();
    t_zero_regs();
    t_unknown();
    t_direct();
    t_sg();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule